// File: doc/BRIEF.md
# Programmable I/O Wait State Generator

This block produces the ready qualifier that ends CPU I/O bus cycles on an 8-bit expansion bus system. It watches the active-low I/O read and I/O write strobes. When either strobe appears it loads a wait count from a 3-bit configuration field. The field allows 0 to 4 CPU clocks, and any larger code acts as 4. The block raises its ready output only once that count has run out. An expansion card can stretch the cycle by pulling the bus channel-ready line low. A fast card can cut the cycle short by asserting the zero-wait request, which overrides the programmed count.

Channel ready and the zero-wait request come from the bus and are not timed to the CPU clock, so each passes through a two-flop synchroniser. The strobes and the configuration field are taken as already synchronous to the CPU clock. The ready output is a register. It is low while no strobe is active, and once high it stays high until the strobe ends. The counter reloads on every idle clock, so back-to-back cycles separated by a single idle clock each get the full count.

Top module: `io_wait_gen`

## Requirements
- R1: While reset is asserted, and on the first sample after it is released with both strobes high, `ready` is low.
- R2: After any clock edge at which both `io_rd_n` and `io_wr_n` are sampled high, `ready` is low, even if the zero-wait request and channel ready are both active.
- R3: Number the clock edges from 1, where edge 1 is the first edge that samples a strobe low. If `wait_cfg` = N with N in 0..4, and the zero-wait request is inactive and channel ready high throughout, `ready` goes high after edge N+2 and not before. The cycle then has N wait states.
- R4: `wait_cfg` codes 5, 6 and 7 give the same timing as code 4, so `ready` goes high after edge 6.
- R5: If `zws_n` is low long enough to be synchronised before the strobe falls, `ready` goes high after edge 1, whatever the `wait_cfg` value.
- R6: If `zws_n` falls during a cycle just after edge j, `ready` goes high after edge j+3, unless the count has already raised it earlier.
- R7: While synchronised `chrdy` is low, `ready` stays low. If `chrdy` rises just after edge j, `ready` goes high after edge max(N+2, j+3).
- R8: Once `ready` is high it stays high as long as a strobe stays low, even if `chrdy` drops.
- R9: A read strobe and a write strobe give identical timing. A new strobe after a single idle clock starts a fresh full count.
- R10: `wait_cfg` is captured at edge 1. Changing it later in the same cycle has no effect on that cycle's timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_rd_n | input | 1 | I/O read strobe, active low, synchronous to clk |
| io_wr_n | input | 1 | I/O write strobe, active low, synchronous to clk |
| chrdy | input | 1 | Bus channel ready from cards, low stretches the cycle, asynchronous |
| zws_n | input | 1 | Zero-wait request from a fast card, active low, asynchronous |
| wait_cfg | input | 3 | Programmed I/O wait states, 0..4, higher codes act as 4 |
| ready | output | 1 | Registered I/O cycle ready to the CPU, high = cycle may end |

## Verification
On every cycle, the assertions check four things. Ready stays low after idle samples. It rises only during a strobe and never before the captured count plus two edges unless zero-wait was seen. It is never raised while synchronised channel ready is low, and it holds until the strobe ends. The counter must also never exceed the maximum wait count. The exact edge at which ready rises is shown only by the bench's scenarios. So is the added delay of the synchronisers when a card releases channel ready or requests zero-wait partway through a cycle. The same holds for the clamping of codes 5 to 7, for cutting a cycle short with a zero-wait request, and for ignoring a configuration change after the first edge.

// File: rtl/iow_pkg.sv
package iow_pkg;
  // Width of the configuration field that holds the wait count.
  localparam int CFG_W     = 3;
  // Largest number of wait states that can be inserted.
  localparam int MAX_WAITS = 4;
  // Counter width able to hold 0..MAX_WAITS.
  localparam int CNT_W     = $clog2(MAX_WAITS + 1);
  // Default synchroniser depth for bus-side inputs.
  localparam int SYNC_DEPTH = 2;

  // Map a raw configuration code onto an effective wait count.
  function automatic logic [CNT_W-1:0] clamp_waits(input logic [CFG_W-1:0] code);
    if (int'(code) > MAX_WAITS) return CNT_W'(MAX_WAITS);
    else                        return CNT_W'(code);
  endfunction
endpackage

// File: rtl/iow_sync.sv
module iow_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];
  logic [WIDTH-1:0] stage_d [STAGES];

  // Next-state: each stage takes the one before it.
  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_comb stage_d[s] = async_in;
      end else begin : g_rest
        always_comb stage_d[s] = stage_q[s-1];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= RST_VAL;
        else        stage_q[s] <= stage_d[s];
      end
    end
  endgenerate

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/iow_counter.sv
module iow_counter
  import iow_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe,
  input  logic [CFG_W-1:0] wait_cfg,
  output logic [CNT_W-1:0] cnt,
  output logic             expired
);
  logic             strobe_q, strobe_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             load;

  // Reload on every idle clock and on the first clock of a cycle.
  assign load = !strobe || !strobe_q;

  always_comb begin
    strobe_d = strobe;
    cnt_d    = cnt_q;
    if (load)              cnt_d = clamp_waits(wait_cfg);
    else if (cnt_q != '0)  cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      cnt_q    <= '0;
    end else begin
      strobe_q <= strobe_d;
      cnt_q    <= cnt_d;
    end
  end

  assign cnt     = cnt_q;
  // The count counts as spent only once a cycle is already under way.
  assign expired = strobe_q && (cnt_q == '0);
endmodule

// File: rtl/iow_ready.sv
module iow_ready (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic expired,
  input  logic chrdy_s,
  input  logic zws_s,
  output logic ready
);
  logic ready_q, ready_d;

  // Ready latches high for the rest of the strobe once any end condition is met.
  always_comb begin
    ready_d = strobe && (ready_q || zws_s || (expired && chrdy_s));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= ready_d;
  end

  assign ready = ready_q;
endmodule

// File: rtl/io_wait_gen.sv
module io_wait_gen
  import iow_pkg::*;
#(
  parameter int SYNC_STAGES = SYNC_DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             io_rd_n,
  input  logic             io_wr_n,
  input  logic             chrdy,
  input  logic             zws_n,
  input  logic [CFG_W-1:0] wait_cfg,
  output logic             ready
);
  localparam int BUS_IN_W = 2;

  logic                io_strobe;
  logic [BUS_IN_W-1:0] bus_raw, bus_sync;
  logic                chrdy_sync, zws_sync;
  logic [CNT_W-1:0]    wait_cnt;
  logic                cnt_done;

  assign io_strobe = !io_rd_n || !io_wr_n;

  // Bit 1: channel ready, bit 0: zero-wait request (active high internally).
  assign bus_raw = {chrdy, !zws_n};

  iow_sync #(
    .WIDTH  (BUS_IN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL('0)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_in(bus_raw),
    .sync_out(bus_sync)
  );

  assign chrdy_sync = bus_sync[1];
  assign zws_sync   = bus_sync[0];

  iow_counter u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobe  (io_strobe),
    .wait_cfg(wait_cfg),
    .cnt     (wait_cnt),
    .expired (cnt_done)
  );

  iow_ready u_rdy (
    .clk    (clk),
    .rst_n  (rst_n),
    .strobe (io_strobe),
    .expired(cnt_done),
    .chrdy_s(chrdy_sync),
    .zws_s  (zws_sync),
    .ready  (ready)
  );
endmodule

// File: rtl/iow_chk.sv
module iow_chk
  import iow_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             io_rd_n,
  input logic             io_wr_n,
  input logic [CFG_W-1:0] wait_cfg,
  input logic             ready,
  input logic             zws_s,
  input logic             chrdy_s,
  input logic [CNT_W-1:0] cnt
);
  localparam int AGE_W   = CNT_W + 1;
  localparam int AGE_MAX = (1 << AGE_W) - 1;

  logic             act, act_q;
  logic [AGE_W-1:0] age_q;
  logic [CFG_W-1:0] cfg_lat;

  assign act = !io_rd_n || !io_wr_n;

  // Independent tracking of edges since a strobe was first seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q   <= 1'b0;
      age_q   <= '0;
      cfg_lat <= '0;
    end else begin
      act_q <= act;
      if (!act)                       age_q <= '0;
      else if (int'(age_q) < AGE_MAX) age_q <= age_q + AGE_W'(1);
      if (act && !act_q) cfg_lat <= wait_cfg;
    end
  end

  // R2
  idle_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd_n && io_wr_n) |=> !ready);

  // R2
  rise_needs_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(act));

  // R8
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && act) |=> ready);

  // R3
  min_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(zws_s)) |-> (int'(age_q) >= int'(clamp_waits(cfg_lat)) + 2));

  // R7
  chrdy_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(zws_s)) |-> $past(chrdy_s));

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt) <= MAX_WAITS);
endmodule

bind io_wait_gen iow_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .io_rd_n (io_rd_n),
  .io_wr_n (io_wr_n),
  .wait_cfg(wait_cfg),
  .ready   (ready),
  .zws_s   (zws_sync),
  .chrdy_s (chrdy_sync),
  .cnt     (wait_cnt)
);

// File: tb/test_io_wait_gen.sv
`timescale 1ns/1ps
module test_io_wait_gen;
  logic       clk, rst_n, io_rd_n, io_wr_n, chrdy, zws_n, ready;
  logic [2:0] wait_cfg;
  int n_cmp, n_bad;
  bit done;

  io_wait_gen i_io_wait_gen (
    .clk(clk), .rst_n(rst_n), .io_rd_n(io_rd_n), .io_wr_n(io_wr_n),
    .chrdy(chrdy), .zws_n(zws_n), .wait_cfg(wait_cfg), .ready(ready)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int eff_n(input int cfg);
    return (cfg > 4) ? 4 : cfg;
  endfunction

  // Edge number after which ready is expected high (requirements R3..R7).
  function automatic int exp_rise(input int cfg, input int zmode, input int zj,
                                  input int cmode, input int cj);
    int norm, zr;
    if (zmode == 1) return 1;
    norm = eff_n(cfg) + 2;
    if (cmode == 1 && cj + 3 > norm) norm = cj + 3;
    zr = (zmode == 2) ? zj + 3 : 1000;
    return (zr < norm) ? zr : norm;
  endfunction

  // zmode: 0 none, 1 preset before strobe, 2 asserted after edge zj
  // cmode: 0 chrdy high, 1 chrdy low then released after edge cj
  task automatic run_txn(input int cfg, input bit use_wr, input int zmode, input int zj,
                         input int cmode, input int cj, input int idle,
                         input int cfg_late, input string tag);
    int k, rise, expk;
    expk = exp_rise(cfg, zmode, zj, cmode, cj);
    @(negedge clk);
    io_rd_n  = 1'b1; io_wr_n = 1'b1;
    wait_cfg = 3'(cfg);
    chrdy    = (cmode == 0);
    zws_n    = (zmode == 1) ? 1'b0 : 1'b1;
    for (int i = 0; i < idle; i++) begin
      @(negedge clk);
      check("R2 idle ready", int'(ready), 0);
    end
    if (use_wr) io_wr_n = 1'b0; else io_rd_n = 1'b0;
    if (cmode == 1 && cj == 0) chrdy = 1'b1;
    if (zmode == 2 && zj == 0) zws_n = 1'b0;
    k = 0; rise = -1;
    while (rise < 0 && k < 30) begin
      @(negedge clk);
      k++;
      if (ready) rise = k;
      if (cmode == 1 && cj == k) chrdy = 1'b1;
      if (zmode == 2 && zj == k) zws_n = 1'b0;
      if (cfg_late >= 0 && k == 1) wait_cfg = 3'(cfg_late);
    end
    check(tag, rise, expk);
    // R8: drop channel ready after ready rose; ready must hold.
    chrdy = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R8 ready hold", int'(ready), 1);
    end
    io_rd_n = 1'b1; io_wr_n = 1'b1; chrdy = 1'b1; zws_n = 1'b1;
    @(negedge clk);
    check("R2 ready drop", int'(ready), 0);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1d0));
    n_cmp = 0; n_bad = 0; done = 0;
    rst_n = 1'b0; io_rd_n = 1'b1; io_wr_n = 1'b1; chrdy = 1'b1; zws_n = 1'b1; wait_cfg = 3'd0;
    repeat (3) @(negedge clk);
    check("R1 ready in reset", int'(ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready after reset", int'(ready), 0);

    // R2: zero-wait and channel ready active while idle must not raise ready.
    zws_n = 1'b0;
    repeat (4) @(negedge clk);
    check("R2 idle with zws", int'(ready), 0);
    zws_n = 1'b1;

    // R3 each count, read and write (R9)
    for (int c = 0; c <= 4; c++) begin
      run_txn(c, 1'b0, 0, 0, 0, 0, 4, -1, "R3 count read");
      run_txn(c, 1'b1, 0, 0, 0, 0, 4, -1, "R9 count write");
    end
    // R4 clamped codes
    for (int c = 5; c <= 7; c++) run_txn(c, 1'b0, 0, 0, 0, 0, 4, -1, "R4 clamp");
    // R5 zero-wait preset with the largest count
    run_txn(7, 1'b1, 1, 0, 0, 0, 4, -1, "R5 zws preset");
    run_txn(0, 1'b0, 1, 0, 0, 0, 4, -1, "R5 zws preset cfg0");
    // R6 zero-wait mid cycle
    run_txn(4, 1'b0, 2, 1, 0, 0, 4, -1, "R6 zws mid");
    run_txn(4, 1'b0, 2, 4, 0, 0, 4, -1, "R6 zws late");
    // R7 channel ready stretch
    run_txn(0, 1'b0, 0, 0, 1, 6, 4, -1, "R7 chrdy stretch");
    run_txn(4, 1'b1, 0, 0, 1, 1, 4, -1, "R7 chrdy short");
    // R9 back-to-back with a single idle clock
    run_txn(3, 1'b0, 0, 0, 0, 0, 4, -1, "R9 first");
    run_txn(3, 1'b1, 0, 0, 0, 0, 1, -1, "R9 back to back");
    // R10 late configuration changes
    run_txn(4, 1'b0, 0, 0, 0, 0, 4, 0, "R10 cfg late down");
    run_txn(0, 1'b0, 0, 0, 0, 0, 4, 4, "R10 cfg late up");

    // Constrained random mix
    for (int t = 0; t < 300; t++) begin
      int cfg, zm, zj, cm, cj;
      string tag;
      cfg = int'($urandom_range(0, 7));
      zm  = int'($urandom_range(0, 5));
      zm  = (zm >= 3) ? 0 : zm;
      zj  = int'($urandom_range(0, 7));
      cm  = int'($urandom_range(0, 1));
      cj  = int'($urandom_range(0, 8));
      if (zm == 1)      tag = "R5 rand";
      else if (zm == 2) tag = "R6 rand";
      else if (cm == 1) tag = "R7 rand";
      else if (cfg > 4) tag = "R4 rand";
      else              tag = "R3 rand";
      run_txn(cfg, 1'($urandom_range(0, 1)), zm, zj, cm, cj, 4,
              ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 7)) : -1, tag);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule